// File: doc/BRIEF.md
# NIC Host-Interface Control Register File

This block is the host-facing control logic of an ISA Ethernet adapter. It decodes a 16-byte I/O window and holds the registers that the host uses to place and enable the adapter's shared-RAM window, to reset the network controller, and to gate its interrupt. The window base address is built from two separate registers. A low register supplies address bits 18:13 and a high register supplies bits 23:19. The base, the enable and the size of the window are driven out for the memory decoder.

The upper half of the window is a read-only ID area. It holds six station-address bytes, a board-type byte and a checksum byte. The host reads them to identify the card. A soft-reset pulse is issued only when the reset-request bit goes from 0 to 1. A narrow-bus build of the block forces I/O address bit 3 high. In that build every offset reads the ID area, host writes change nothing, and the RAM window is enabled from reset.

Top module: `nic_hostif_regs`

## Requirements
- R1: After reset (wide build), `win_base` equals `INIT_BASE`, `win_en` is 0 and `soft_rst` is 0. Offset 0 reads `INIT_BASE[18:13]` with bits 7:6 clear. Offset 5 reads `INIT_BASE[23:19]` with bits 7:5 clear. Offset 4 reads {`INT_EN_INIT`, `IRQ_CODE[1:0]`, 5'b0}. Offset 1 reads {5'b0, `IRQ_CODE[2]`, `SLOT16`, 1'b0}. Offset 7 reads {1'b0, `RAM_32K`, `SW_CFG`, `CHIP_ID`}.
- R2: A write to offset 0 stores the full byte. From the next cycle, `win_base[18:13]` equals data bits 5:0 and `win_en` equals data bit 6.
- R3: A write to offset 5 stores the full byte, which reads back unchanged. From the next cycle, `win_base[23:19]` equals data bits 4:0. `win_base[12:0]` is always 0.
- R4: `soft_rst` is high for exactly one cycle, the cycle after a write to offset 0 with data bit 7 set while the stored bit 7 was 0. A write with bit 7 set while it is already set gives no pulse.
- R5: A write to offset 4 replaces only bits 4:0. Bits 7:5 keep their value.
- R6: `irq_out` equals `irq_in` while offset-4 bit 7 is 1 and is 0 while it is 0, with no cycle of delay.
- R7: Offsets 1 and 7 read back the full byte last written. `win_size_32k` equals offset-7 bit 6.
- R8: Reads of offsets 8 to D return the station-address bytes, most significant byte of `STATION_ADDR` first at offset 8. Offset E returns `BOARD_TYPE`.
- R9: Offset F returns 0xFF minus the low 8 bits of the sum of the seven bytes at offsets 8 to E.
- R10: Narrow build: I/O address bit 3 is forced to 1 on reads, so offset n reads as offset n|8. Host writes change no register, `soft_rst` never rises, and `win_en` is 1 from reset with `win_base` equal to `INIT_BASE`.
- R11: Offsets 2, 3 and 6 read as 0, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4 | Offset within the 16-byte I/O window |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| win_base | output | 24 | Shared-RAM window base address |
| win_en | output | 1 | Shared-RAM window enable |
| win_size_32k | output | 1 | Window size: 1 = 32 KB, 0 = 16 KB |
| soft_rst | output | 1 | One-cycle reset pulse to the network controller |
| irq_in | input | 1 | Interrupt request from the network controller |
| irq_out | output | 1 | Gated interrupt to the host |

## Verification
The main stimulus is a series of writes to the two address registers with different bit patterns: all ones in the low field, a non-zero high field with its upper bits set, and a clear of the enable. These show whether each address field lands in its own slice of `win_base` and whether the control bits that share those registers leak into the address. The reset-request bit is written twice in a row with bit 7 set and then cleared and set again, which separates edge-triggered behaviour from level-triggered behaviour. The interrupt input is toggled under both enable settings, and a masked write to offset 4 shows whether the protected upper bits survive. Full sweeps of all sixteen offsets on the wide and narrow builds together cover the ID area, the checksum and the address aliasing.

// File: rtl/nic_hostif_pkg.sv
// Shared definitions for the NIC host-interface register file.
// Assumes a 24-bit host memory address space and a 16-byte I/O window.
package nic_hostif_pkg;

    localparam int ADDR_W   = 24;
    localparam int LO_LSB   = 13;   // window address bit fed by memsel[0]
    localparam int HI_LSB   = 19;   // window address bit fed by hiaddr[0]
    localparam int LO_BITS  = HI_LSB - LO_LSB;
    localparam int HI_BITS  = ADDR_W - HI_LSB;
    localparam int STA_BYTES = 6;

    localparam logic [3:0] OFS_MEMSEL = 4'h0;
    localparam logic [3:0] OFS_IFCFG  = 4'h1;
    localparam logic [3:0] OFS_IRQREQ = 4'h4;
    localparam logic [3:0] OFS_HIADDR = 4'h5;
    localparam logic [3:0] OFS_CHIPID = 4'h7;

    typedef struct packed {
        logic [7:0] memsel;
        logic [7:0] ifcfg;
        logic [7:0] irqreq;
        logic [7:0] hiaddr;
        logic [7:0] chipid;
    } ctl_regs_t;

    // Checksum byte: 0xFF minus the low byte of the sum of the ID bytes.
    function automatic logic [7:0] id_checksum(input logic [8*STA_BYTES-1:0] sta,
                                               input logic [7:0] board);
        logic [7:0] acc;
        acc = board;
        for (int i = 0; i < STA_BYTES; i++) acc = acc + sta[8*i +: 8];
        return 8'hFF - acc;
    endfunction

endpackage

// File: rtl/nic_ctl_regs.sv
// Control register file: memory-select, interface-config, interrupt-request,
// high-address and chip-ID registers, plus the edge-triggered soft reset.
// Assumes one byte write per cycle on an already-aliased offset.
module nic_ctl_regs
    import nic_hostif_pkg::*;
#(
    parameter bit                 NARROW_BUS  = 1'b0,
    parameter logic [ADDR_W-1:0]  INIT_BASE   = 24'h0D0000,
    parameter logic [2:0]         IRQ_CODE    = 3'd1,
    parameter bit                 INT_EN_INIT = 1'b1,
    parameter bit                 SLOT16      = 1'b1,
    parameter logic [4:0]         CHIP_ID     = 5'h05,
    parameter bit                 SW_CFG      = 1'b1,
    parameter bit                 RAM_32K     = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output ctl_regs_t  regs,
    output logic       soft_rst
);

    localparam logic [7:0] MEMSEL_INIT = {1'b0, NARROW_BUS, INIT_BASE[HI_LSB-1:LO_LSB]};
    localparam logic [7:0] HIADDR_INIT = {3'b000, INIT_BASE[ADDR_W-1:HI_LSB]};
    localparam logic [7:0] IRQREQ_INIT = {INT_EN_INIT, IRQ_CODE[1:0], 5'b00000};
    localparam logic [7:0] IFCFG_INIT  = {5'b00000, IRQ_CODE[2], SLOT16, 1'b0};
    localparam logic [7:0] CHIPID_INIT = {1'b0, RAM_32K, SW_CFG, CHIP_ID};

    logic wr_ok;

    // Narrow build: host writes never reach the registers.
    generate
        if (NARROW_BUS) begin : g_narrow
            assign wr_ok = 1'b0;
        end else begin : g_wide
            assign wr_ok = wr_en;
        end
    endgenerate

    // Register update and soft-reset pulse on a 0->1 of memsel bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs.memsel <= MEMSEL_INIT;
            regs.ifcfg  <= IFCFG_INIT;
            regs.irqreq <= IRQREQ_INIT;
            regs.hiaddr <= HIADDR_INIT;
            regs.chipid <= CHIPID_INIT;
            soft_rst    <= 1'b0;
        end else begin
            soft_rst <= wr_ok && (addr == OFS_MEMSEL) && wdata[7] && !regs.memsel[7];
            if (wr_ok) begin
                case (addr)
                    OFS_MEMSEL: regs.memsel <= wdata;
                    OFS_IFCFG:  regs.ifcfg  <= wdata;
                    OFS_IRQREQ: regs.irqreq <= {regs.irqreq[7:5], wdata[4:0]};
                    OFS_HIADDR: regs.hiaddr <= wdata;
                    OFS_CHIPID: regs.chipid <= wdata;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/nic_id_area.sv
// Read-only ID area: station-address bytes, board-type byte, checksum byte.
// Assumes the contents are fixed by parameters; the lookup is combinational.
module nic_id_area
    import nic_hostif_pkg::*;
#(
    parameter logic [8*STA_BYTES-1:0] STATION_ADDR = 48'h0000C0123456,
    parameter logic [7:0]             BOARD_TYPE   = 8'h27
) (
    input  logic [2:0] idx,
    output logic [7:0] data
);

    localparam logic [7:0] CKSUM = id_checksum(STATION_ADDR, BOARD_TYPE);

    logic [7:0] id_bytes [8];

    // Station bytes, most significant first at index 0.
    generate
        for (genvar i = 0; i < STA_BYTES; i++) begin : g_sta
            assign id_bytes[i] = STATION_ADDR[8*(STA_BYTES-1-i) +: 8];
        end
    endgenerate

    assign id_bytes[6] = BOARD_TYPE;
    assign id_bytes[7] = CKSUM;

    // Byte select.
    always_comb data = id_bytes[idx];

endmodule

// File: rtl/nic_win_map.sv
// Shared-RAM window mapper: base from two address fields, enable and size.
// Assumes the fields are register outputs, so the result is glitch-limited.
module nic_win_map
    import nic_hostif_pkg::*;
(
    input  ctl_regs_t         regs,
    output logic [ADDR_W-1:0] base,
    output logic              enable,
    output logic              size_32k
);

    // Concatenate high field, low field and the zero page bits.
    always_comb begin
        base     = {regs.hiaddr[HI_BITS-1:0], regs.memsel[LO_BITS-1:0], {LO_LSB{1'b0}}};
        enable   = regs.memsel[6];
        size_32k = regs.chipid[6];
    end

endmodule

// File: rtl/nic_hostif_regs.sv
// Top of the NIC host-interface control block: I/O decode, read mux,
// window outputs, soft reset and interrupt gate.
// Assumes a synchronous active-low reset and combinational reads.
module nic_hostif_regs
    import nic_hostif_pkg::*;
#(
    parameter bit                     NARROW_BUS   = 1'b0,
    parameter logic [ADDR_W-1:0]      INIT_BASE    = 24'h0D0000,
    parameter logic [2:0]             IRQ_CODE     = 3'd1,
    parameter bit                     INT_EN_INIT  = 1'b1,
    parameter bit                     SLOT16       = 1'b1,
    parameter logic [4:0]             CHIP_ID      = 5'h05,
    parameter bit                     SW_CFG       = 1'b1,
    parameter bit                     RAM_32K      = 1'b0,
    parameter logic [8*STA_BYTES-1:0] STATION_ADDR = 48'h0000C0123456,
    parameter logic [7:0]             BOARD_TYPE   = 8'h27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [ADDR_W-1:0] win_base,
    output logic              win_en,
    output logic              win_size_32k,
    output logic              soft_rst,
    input  logic              irq_in,
    output logic              irq_out
);

    ctl_regs_t  regs;
    logic [3:0] eff_addr;
    logic [7:0] id_data;
    logic [2:0] irq_hi;

    // Narrow build aliases the low half onto the ID area.
    assign eff_addr = NARROW_BUS ? (io_addr | 4'h8) : io_addr;
    assign irq_hi   = regs.irqreq[7:5];

    nic_ctl_regs #(
        .NARROW_BUS (NARROW_BUS),
        .INIT_BASE  (INIT_BASE),
        .IRQ_CODE   (IRQ_CODE),
        .INT_EN_INIT(INT_EN_INIT),
        .SLOT16     (SLOT16),
        .CHIP_ID    (CHIP_ID),
        .SW_CFG     (SW_CFG),
        .RAM_32K    (RAM_32K)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (io_wr),
        .addr    (eff_addr),
        .wdata   (io_wdata),
        .regs    (regs),
        .soft_rst(soft_rst)
    );

    nic_id_area #(
        .STATION_ADDR(STATION_ADDR),
        .BOARD_TYPE  (BOARD_TYPE)
    ) u_id (
        .idx (eff_addr[2:0]),
        .data(id_data)
    );

    nic_win_map u_map (
        .regs    (regs),
        .base    (win_base),
        .enable  (win_en),
        .size_32k(win_size_32k)
    );

    // Read mux: ID area in the upper half, registers in the lower half.
    always_comb begin
        if (eff_addr[3]) begin
            io_rdata = id_data;
        end else begin
            case (eff_addr)
                OFS_MEMSEL: io_rdata = regs.memsel;
                OFS_IFCFG:  io_rdata = regs.ifcfg;
                OFS_IRQREQ: io_rdata = regs.irqreq;
                OFS_HIADDR: io_rdata = regs.hiaddr;
                OFS_CHIPID: io_rdata = regs.chipid;
                default:    io_rdata = 8'h00;
            endcase
        end
    end

    // Interrupt gate on the enable bit.
    assign irq_out = irq_in & regs.irqreq[7];

endmodule

// File: rtl/nic_hostif_sva.sv
// Checker for nic_hostif_regs, bound to every instance of the top.
// Assumes the synchronous active-low reset of the design.
module nic_hostif_sva #(
    parameter bit NARROW_BUS = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  io_addr,
    input logic        io_wr,
    input logic [7:0]  io_wdata,
    input logic [23:0] win_base,
    input logic        win_en,
    input logic        soft_rst,
    input logic        irq_in,
    input logic        irq_out,
    input logic [2:0]  irq_hi
);

    p_srst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    p_srst_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> $past(io_wr && (io_addr == 4'h0) && io_wdata[7]));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_in |-> !irq_out);

    p_win_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> ($stable(win_base) && $stable(win_en)));

    p_irq_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(irq_hi));

    generate
        if (NARROW_BUS) begin : g_narrow_chk
            p_narrow_win_r10: assert property (@(posedge clk) disable iff (!rst_n)
                win_en && !soft_rst);
        end
    endgenerate

endmodule

bind nic_hostif_regs nic_hostif_sva #(.NARROW_BUS(NARROW_BUS)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_wdata(io_wdata),
    .win_base(win_base),
    .win_en  (win_en),
    .soft_rst(soft_rst),
    .irq_in  (irq_in),
    .irq_out (irq_out),
    .irq_hi  (irq_hi)
);

// File: tb/nic_hostif_regs_tb_top.sv
// Bench for nic_hostif_regs: a behavioural reference model compared on every
// clock, plus directed checks. Two instances share one bus: a wide build
// (dut_i) and a narrow build with the interrupt gate closed (dut_n).
module nic_hostif_regs_tb_top;

    localparam logic [47:0] STA   = 48'h0000C0123456;
    localparam logic [7:0]  BTYPE = 8'h27;
    localparam int          BASE0 = 24'h0D0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = 4'h0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic        irq_in = 1'b0;

    logic [7:0]  rd_i, rd_n;
    logic [23:0] base_i, base_n;
    logic        en_i, en_n, sz_i, sz_n, srst_i, srst_n, irq_i, irq_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    bit live = 0;

    // Reference model state (wide build)
    int m_memsel, m_ifcfg, m_irq, m_hi, m_chip, m_srst;

    always #10 clk = ~clk;

    nic_hostif_regs dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(rd_i), .win_base(base_i), .win_en(en_i), .win_size_32k(sz_i),
        .soft_rst(srst_i), .irq_in(irq_in), .irq_out(irq_i));

    nic_hostif_regs #(.NARROW_BUS(1'b1), .INT_EN_INIT(1'b0)) dut_n (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(rd_n), .win_base(base_n), .win_en(en_n), .win_size_32k(sz_n),
        .soft_rst(srst_n), .irq_in(irq_in), .irq_out(irq_n));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int id_byte(input int a);
        int s;
        if (a < 6) return (STA >> (8 * (5 - a))) & 8'hFF;
        if (a == 6) return BTYPE;
        s = BTYPE;
        for (int k = 0; k < 6; k++) s += (STA >> (8 * k)) & 8'hFF;
        return 255 - (s % 256);
    endfunction

    function automatic int exp_rd(input int a);
        if (a >= 8) return id_byte(a - 8);
        case (a)
            0: return m_memsel;
            1: return m_ifcfg;
            4: return m_irq;
            5: return m_hi;
            7: return m_chip;
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(input int a);
        case (a)
            0: return "R2 rdata";
            1: return "R7 rdata";
            4: return "R5 rdata";
            5: return "R3 rdata";
            7: return "R7 rdata";
            15: return "R9 rdata";
            default: return (a >= 8) ? "R8 rdata" : "R11 rdata";
        endcase
    endfunction

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_memsel = (BASE0 >> 13) & 8'h3F;
            m_hi     = (BASE0 >> 19) & 8'h1F;
            m_irq    = 8'hA0;
            m_ifcfg  = 8'h02;
            m_chip   = 8'h25;
            m_srst   = 0;
        end else begin
            m_srst = (io_wr && io_addr == 0 && io_wdata[7] && !m_memsel[7]) ? 1 : 0;
            if (io_wr) begin
                case (io_addr)
                    0: m_memsel = io_wdata;
                    1: m_ifcfg  = io_wdata;
                    4: m_irq    = (m_irq & 8'hE0) | (io_wdata & 8'h1F);
                    5: m_hi     = io_wdata;
                    7: m_chip   = io_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Compare both instances with the model on every falling edge.
    always @(negedge clk) begin
        if (live) begin
            chk(rd_tag(io_addr), rd_i, exp_rd(io_addr));
            chk("R2/R3 win_base", base_i, ((m_hi & 8'h1F) << 19) | ((m_memsel & 8'h3F) << 13));
            chk("R2 win_en", en_i, (m_memsel >> 6) & 1);
            chk("R7 win_size_32k", sz_i, (m_chip >> 6) & 1);
            chk("R4 soft_rst", srst_i, m_srst);
            chk("R6 irq_out", irq_i, irq_in & ((m_irq >> 7) & 1));
            chk("R10 narrow rdata", rd_n, id_byte(io_addr & 7));
            chk("R10 narrow win", {base_n, en_n, srst_n}, {BASE0[23:0], 1'b1, 1'b0});
            chk("R6 narrow irq gated", irq_n, 0);
        end
    end

    task automatic io_write(input int a, input int d);
        @(negedge clk); #2;
        io_addr = a[3:0]; io_wdata = d[7:0]; io_wr = 1'b1;
        @(negedge clk); #2;
        io_wr = 1'b0;
    endtask

    task automatic io_point(input int a);
        @(negedge clk); #2;
        io_addr = a[3:0];
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        live = 1;
        // R1: reset state
        io_point(0);
        @(negedge clk); #1;
        chk("R1 memsel reset", rd_i, 8'h28);
        chk("R1 base reset", base_i, 24'h0D0000);
        chk("R1 win_en reset", en_i, 0);
        chk("R1 soft_rst reset", srst_i, 0);
        io_point(4); #1 chk("R1 irqreq reset", rd_i, 8'hA0);
        io_point(7); #1 chk("R1 chipid reset", rd_i, 8'h25);
        // R8 R9 R11: sweep every offset
        for (int a = 0; a < 16; a++) io_point(a);
        // R2: low address field and enable
        io_write(0, 8'h7F);
        chk("R2 base after write", base_i, 24'h0FE000);
        chk("R2 enable after write", en_i, 1);
        // R3: high address field, control bits read back
        io_write(5, 8'hE3);
        chk("R3 base after write", base_i, 24'h1FE000);
        io_point(5); #1 chk("R3 hiaddr readback", rd_i, 8'hE3);
        // R4: edge-triggered soft reset
        io_write(0, 8'hBF);
        chk("R4 pulse high", srst_i, 1);
        @(negedge clk); #1 chk("R4 pulse one cycle", srst_i, 0);
        io_write(0, 8'hBF);
        chk("R4 no pulse when already set", srst_i, 0);
        io_write(0, 8'h3F);
        io_write(0, 8'h80);
        chk("R4 pulse after clear", srst_i, 1);
        chk("R2 disable clears win_en", en_i, 0);
        // R5: masked write to interrupt register
        io_write(4, 8'hFF);
        io_point(4); #1 chk("R5 upper bits kept", rd_i, 8'hBF);
        io_write(4, 8'h00);
        io_point(4); #1 chk("R5 low bits cleared", rd_i, 8'hA0);
        // R6: interrupt gate
        irq_in = 1'b1; #1;
        chk("R6 pass when enabled", irq_i, 1);
        chk("R6 blocked when disabled", irq_n, 0);
        @(negedge clk); irq_in = 1'b0; #1;
        chk("R6 follows low", irq_i, 0);
        // R7: full-byte registers and size select
        io_write(1, 8'h5A);
        io_point(1); #1 chk("R7 ifcfg readback", rd_i, 8'h5A);
        io_write(7, 8'h65);
        chk("R7 size 32k", sz_i, 1);
        // R11: unused offsets
        io_write(2, 8'h77);
        io_write(6, 8'hFF);
        io_point(2); #1 chk("R11 offset 2 reads 0", rd_i, 0);
        io_point(3); #1 chk("R11 offset 3 reads 0", rd_i, 0);
        // R8 R9 R10: explicit ID bytes through both builds
        io_point(8); #1 chk("R8 first station byte", rd_i, 8'h00);
        io_point(13); #1 chk("R8 last station byte", rd_i, 8'h56);
        io_point(14); #1 chk("R8 board type", rd_i, 8'h27);
        io_point(15); #1 chk("R9 checksum", rd_i, id_byte(7));
        io_point(0); #1 chk("R10 alias of offset 0", rd_n, 8'h00);
        chk("R10 narrow base", base_n, BASE0);
        io_point(7); #1 chk("R10 alias of offset 7", rd_n, id_byte(7));
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule